// File: doc/BRIEF.md
# Station Address Match Filter

This block decides whether a received frame is meant for this station. It holds a table of up to sixteen six-byte station addresses and a sixteen-bit mask that enables each entry. When a destination address arrives with its strobe, the block returns an accept flag, a type code and the index of the table entry that matched. The type code can be ORed directly into a receive status word.

Three mode inputs are tested before the table search, in a fixed priority order. First comes promiscuous acceptance of unicast. Next comes acceptance of every group address. Then comes acceptance of the all-ones broadcast address. After these, the enabled table entries are searched from the lowest index upward. The table is filled by a load sequence of sixteen-bit words: three words for each entry, then one mask word. A small state machine runs this sequence. Its states are LD_IDLE, LD_W0, LD_W1, LD_W2 and LD_MASK.

- LD_IDLE moves to LD_W0 on `load_start` when the entry count is non-zero.
- LD_IDLE moves to LD_MASK on `load_start` when the entry count is zero.
- LD_W0 moves to LD_W1, and LD_W1 moves to LD_W2, on each accepted word.
- LD_W2 moves to LD_W0 when entries remain after the decrement, and to LD_MASK when none remain.
- LD_MASK returns to LD_IDLE when the mask word is accepted.

While the controller is held in reset mode, the host can read any entry back as three words.

Top module: `addr_cam_filter`

## Requirements
- R1: After `rst_n` is asserted, every table entry and the enable mask are zero. `accept`, `rx_type`, `hit_entry`, `load_busy`, `load_done` and `load_left` are all zero.
- R2: A `load_start` pulse in LD_IDLE takes the entry count from bits [4:0] of `load_count` and ignores the upper bits. The sequence then fills entries from index 0 upward, wrapping modulo 16. Each entry takes three words in turn. Word k gives address byte 2k in bits [7:0] and byte 2k+1 in bits [15:8]. Words are taken only on cycles where `word_valid` is high.
- R3: `load_left` shows the remaining entry count. It drops by exactly one in the cycle after the third word of an entry is accepted.
- R4: After the last entry, or at once when the count is zero, the next accepted word becomes the enable mask, where bit i enables entry i. `load_done` then pulses high for one cycle, in the same cycle that `load_busy` falls.
- R5: When `promisc_en` is 1 and `dst_addr[0]` is 0, the frame is accepted with type 0x0000. This test has the highest priority.
- R6: Otherwise, when `mcast_en` is 1 and `dst_addr[0]` is 1, the frame is accepted with type 0x0100. This includes the broadcast address.
- R7: Otherwise, when `bcast_en` is 1 and all 48 address bits are 1, the frame is accepted with type 0x0080.
- R8: Otherwise, the frame is accepted with type 0x0000 only if an enabled entry equals all 48 bits of `dst_addr`, where `dst_addr[7:0]` is byte 0. `hit_entry` gives the lowest matching index. With no match, `accept` and `hit_entry` are 0. `hit_entry` is also 0 on every non-table accept.
- R9: `accept`, `rx_type` and `hit_entry` change only in the cycle after a `dst_valid` strobe, and are held until the next strobe. The classification uses the table contents present at the strobe.
- R10: `rd_data` gives word `rd_sel` (0 to 2, with the same byte layout as loading) of entry `rd_ptr` only while `in_reset` is 1. When `in_reset` is 0, or `rd_sel` is 3, `rd_data` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_reset | input | 1 | Controller reset mode; enables readback |
| load_start | input | 1 | Starts a table load sequence |
| load_count | input | 16 | Entry count register value; bits [4:0] are used |
| word_valid | input | 1 | Load word is present |
| word_data | input | 16 | Load word |
| load_busy | output | 1 | Load sequence in progress |
| load_done | output | 1 | One-cycle pulse when the mask word is taken |
| load_left | output | 5 | Entries still to load |
| rd_ptr | input | 4 | Entry selected for readback |
| rd_sel | input | 2 | Word of the entry selected for readback |
| rd_data | output | 16 | Readback word |
| promisc_en | input | 1 | Accept all unicast |
| mcast_en | input | 1 | Accept all group addresses |
| bcast_en | input | 1 | Accept broadcast |
| dst_valid | input | 1 | Destination address strobe |
| dst_addr | input | 48 | Destination address, byte 0 in bits [7:0] |
| accept | output | 1 | Frame accepted |
| rx_type | output | 16 | 0x0080 broadcast, 0x0100 multicast, 0 otherwise |
| hit_entry | output | 4 | First matching table index |

## Verification
The embedded assertions check several rules on every cycle:
- the held value of the result between strobes,
- the at-most-one-hot type code, and that it is zero whenever the frame is rejected,
- the forced broadcast result,
- the one-step count decrement,
- that `load_done` coincides with the end of the busy window,
- that readback is zero outside reset mode.

Other behaviour only the bench's scenarios can show, against its behavioural model: that an entry is disabled by its mask bit, that a lower duplicate entry wins, that the modes follow their priority order, that load words land in the right byte lanes, and that the upper count bits are ignored.

// File: rtl/cam_pkg.sv
package cam_pkg;
    typedef enum logic [2:0] {
        LD_IDLE,
        LD_W0,
        LD_W1,
        LD_W2,
        LD_MASK
    } ld_state_e;

    localparam logic [15:0] TYPE_BCAST = 16'h0080;
    localparam logic [15:0] TYPE_MCAST = 16'h0100;
    localparam logic [15:0] TYPE_UCAST = 16'h0000;
endpackage

// File: rtl/cam_loader.sv
module cam_loader
    import cam_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int CNTW    = 5,
    parameter int WORDW   = 16,
    localparam int IDXW   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_start,
    input  logic [CNTW-1:0]  count_in,
    input  logic             word_valid,
    input  logic [WORDW-1:0] word_data,
    output logic             wr_en,
    output logic [IDXW-1:0]  wr_idx,
    output logic [1:0]       wr_sel,
    output logic             mask_wr,
    output logic [WORDW-1:0] wr_data,
    output logic             busy,
    output logic             done,
    output logic [CNTW-1:0]  left
);
    ld_state_e       state_q, state_d;
    logic [CNTW-1:0] cnt_q;
    logic [IDXW-1:0] idx_q;
    logic            done_q;
    logic [CNTW-1:0] cnt_dec;

    assign cnt_dec = cnt_q - 1'b1;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LD_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LD_IDLE: if (load_start) state_d = (count_in != '0) ? LD_W0 : LD_MASK;
            LD_W0:   if (word_valid) state_d = LD_W1;
            LD_W1:   if (word_valid) state_d = LD_W2;
            LD_W2:   if (word_valid) state_d = (cnt_dec != '0) ? LD_W0 : LD_MASK;
            LD_MASK: if (word_valid) state_d = LD_IDLE;
            default: state_d = LD_IDLE;
        endcase
    end

    // counters and done pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            idx_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= (state_q == LD_MASK) && word_valid;
            if (state_q == LD_IDLE && load_start) begin
                cnt_q <= count_in;
                idx_q <= '0;
            end else if (state_q == LD_W2 && word_valid) begin
                cnt_q <= cnt_dec;
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        wr_en   = 1'b0;
        wr_sel  = 2'd0;
        mask_wr = 1'b0;
        unique case (state_q)
            LD_IDLE: ;
            LD_W0:   begin wr_en = word_valid; wr_sel = 2'd0; end
            LD_W1:   begin wr_en = word_valid; wr_sel = 2'd1; end
            LD_W2:   begin wr_en = word_valid; wr_sel = 2'd2; end
            LD_MASK: mask_wr = word_valid;
            default: ;
        endcase
    end

    assign wr_idx  = idx_q;
    assign wr_data = word_data;
    assign busy    = (state_q != LD_IDLE);
    assign done    = done_q;
    assign left    = cnt_q;

    // R3: one entry finished lowers the count by exactly one
    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LD_W2 && word_valid) |=> (cnt_q == CNTW'($past(cnt_q) - 1'b1)));

    // R4: the done pulse marks the end of the busy window
    a_r4_done_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
endmodule

// File: rtl/cam_store.sv
module cam_store #(
    parameter int ENTRIES = 16,
    parameter int WORDW   = 16,
    parameter int AW      = 48,
    localparam int IDXW   = $clog2(ENTRIES),
    localparam int NWORDS = AW / WORDW
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [IDXW-1:0]              wr_idx,
    input  logic [1:0]                   wr_sel,
    input  logic                         mask_wr,
    input  logic [WORDW-1:0]             wr_data,
    input  logic                         in_reset,
    input  logic [IDXW-1:0]              rd_ptr,
    input  logic [1:0]                   rd_sel,
    output logic [WORDW-1:0]             rd_data,
    output logic [ENTRIES-1:0][AW-1:0]   entries,
    output logic [ENTRIES-1:0]           enables
);
    logic [ENTRIES-1:0][AW-1:0] ent_q;
    logic [ENTRIES-1:0]         en_q;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
        for (genvar w = 0; w < NWORDS; w++) begin : g_word
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    ent_q[i][w*WORDW +: WORDW] <= '0;
                else if (wr_en && wr_idx == IDXW'(i) && wr_sel == 2'(w))
                    ent_q[i][w*WORDW +: WORDW] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       en_q <= '0;
        else if (mask_wr) en_q <= wr_data[ENTRIES-1:0];
    end

    always_comb begin
        rd_data = '0;
        if (in_reset && int'(rd_sel) < NWORDS)
            rd_data = ent_q[rd_ptr][int'(rd_sel)*WORDW +: WORDW];
    end

    assign entries = ent_q;
    assign enables = en_q;

    // R10: no readback outside reset mode
    a_r10_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !in_reset |-> (rd_data == '0));
endmodule

// File: rtl/cam_match.sv
module cam_match
    import cam_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int AW      = 48,
    localparam int IDXW   = $clog2(ENTRIES)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ENTRIES-1:0][AW-1:0] entries,
    input  logic [ENTRIES-1:0]         enables,
    input  logic                       promisc_en,
    input  logic                       mcast_en,
    input  logic                       bcast_en,
    input  logic                       dst_valid,
    input  logic [AW-1:0]              dst_addr,
    output logic                       accept,
    output logic [15:0]                rx_type,
    output logic [IDXW-1:0]            hit_entry
);
    logic [ENTRIES-1:0] hit;
    logic               any_hit;
    logic [IDXW-1:0]    first_idx;
    logic               acc_d;
    logic [15:0]        type_d;
    logic [IDXW-1:0]    idx_d;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign hit[i] = enables[i] && (entries[i] == dst_addr);
    end

    assign any_hit = |hit;

    // lowest index wins
    always_comb begin
        first_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--)
            if (hit[i]) first_idx = IDXW'(i);
    end

    always_comb begin
        acc_d  = 1'b0;
        type_d = TYPE_UCAST;
        idx_d  = '0;
        if (promisc_en && !dst_addr[0]) begin
            acc_d = 1'b1;
        end else if (mcast_en && dst_addr[0]) begin
            acc_d  = 1'b1;
            type_d = TYPE_MCAST;
        end else if (bcast_en && (&dst_addr)) begin
            acc_d  = 1'b1;
            type_d = TYPE_BCAST;
        end else if (any_hit) begin
            acc_d = 1'b1;
            idx_d = first_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            accept    <= 1'b0;
            rx_type   <= '0;
            hit_entry <= '0;
        end else if (dst_valid) begin
            accept    <= acc_d;
            rx_type   <= type_d;
            hit_entry <= idx_d;
        end
    end

    // R9: result held between strobes
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !dst_valid |=> ($stable(accept) && $stable(rx_type) && $stable(hit_entry)));

    // R7: broadcast with only broadcast mode on
    a_r7_bcast: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_valid && bcast_en && !mcast_en && (&dst_addr)) |=> (accept && rx_type == TYPE_BCAST));

    // R6: at most one type bit, none on reject
    a_r6_type_code: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rx_type) && (accept || rx_type == '0));
endmodule

// File: rtl/addr_cam_filter.sv
module addr_cam_filter #(
    parameter int ENTRIES = 16,
    parameter int CNTW    = 5,
    parameter int WORDW   = 16,
    parameter int AW      = 48,
    localparam int IDXW   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_reset,
    input  logic             load_start,
    input  logic [15:0]      load_count,
    input  logic             word_valid,
    input  logic [WORDW-1:0] word_data,
    output logic             load_busy,
    output logic             load_done,
    output logic [CNTW-1:0]  load_left,
    input  logic [IDXW-1:0]  rd_ptr,
    input  logic [1:0]       rd_sel,
    output logic [WORDW-1:0] rd_data,
    input  logic             promisc_en,
    input  logic             mcast_en,
    input  logic             bcast_en,
    input  logic             dst_valid,
    input  logic [AW-1:0]    dst_addr,
    output logic             accept,
    output logic [15:0]      rx_type,
    output logic [IDXW-1:0]  hit_entry
);
    logic                       wr_en, mask_wr;
    logic [IDXW-1:0]            wr_idx;
    logic [1:0]                 wr_sel;
    logic [WORDW-1:0]           wr_data;
    logic [ENTRIES-1:0][AW-1:0] entries;
    logic [ENTRIES-1:0]         enables;

    cam_loader #(.ENTRIES(ENTRIES), .CNTW(CNTW), .WORDW(WORDW)) u_loader (
        .clk(clk), .rst_n(rst_n), .load_start(load_start),
        .count_in(load_count[CNTW-1:0]), .word_valid(word_valid),
        .word_data(word_data), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_sel(wr_sel), .mask_wr(mask_wr), .wr_data(wr_data),
        .busy(load_busy), .done(load_done), .left(load_left)
    );

    cam_store #(.ENTRIES(ENTRIES), .WORDW(WORDW), .AW(AW)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_sel(wr_sel), .mask_wr(mask_wr), .wr_data(wr_data),
        .in_reset(in_reset), .rd_ptr(rd_ptr), .rd_sel(rd_sel),
        .rd_data(rd_data), .entries(entries), .enables(enables)
    );

    cam_match #(.ENTRIES(ENTRIES), .AW(AW)) u_match (
        .clk(clk), .rst_n(rst_n), .entries(entries), .enables(enables),
        .promisc_en(promisc_en), .mcast_en(mcast_en), .bcast_en(bcast_en),
        .dst_valid(dst_valid), .dst_addr(dst_addr), .accept(accept),
        .rx_type(rx_type), .hit_entry(hit_entry)
    );
endmodule

// File: tb/addr_cam_filter_bench.sv
module addr_cam_filter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_reset = 1'b0;
    logic        load_start = 1'b0;
    logic [15:0] load_count = '0;
    logic        word_valid = 1'b0;
    logic [15:0] word_data = '0;
    logic        load_busy, load_done;
    logic [4:0]  load_left;
    logic [3:0]  rd_ptr = '0;
    logic [1:0]  rd_sel = '0;
    logic [15:0] rd_data;
    logic        promisc_en = 1'b0, mcast_en = 1'b0, bcast_en = 1'b0;
    logic        dst_valid = 1'b0;
    logic [47:0] dst_addr = '0;
    logic        accept;
    logic [15:0] rx_type;
    logic [3:0]  hit_entry;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    addr_cam_filter u_addr_cam_filter (
        .clk(clk), .rst_n(rst_n), .in_reset(in_reset),
        .load_start(load_start), .load_count(load_count),
        .word_valid(word_valid), .word_data(word_data),
        .load_busy(load_busy), .load_done(load_done), .load_left(load_left),
        .rd_ptr(rd_ptr), .rd_sel(rd_sel), .rd_data(rd_data),
        .promisc_en(promisc_en), .mcast_en(mcast_en), .bcast_en(bcast_en),
        .dst_valid(dst_valid), .dst_addr(dst_addr), .accept(accept),
        .rx_type(rx_type), .hit_entry(hit_entry)
    );

    // behavioural reference model
    logic [47:0] m_ent [16];
    logic [15:0] m_mask;
    int          m_ph;      // -1 idle, 0..2 entry words, 3 mask
    int          m_cnt, m_idx;
    bit          m_done, m_acc;
    int          m_type, m_hit;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            foreach (m_ent[i]) m_ent[i] = '0;
            m_mask = '0; m_ph = -1; m_cnt = 0; m_idx = 0;
            m_done = 0; m_acc = 0; m_type = 0; m_hit = 0;
        end else begin
            if (dst_valid) begin
                m_acc = 0; m_type = 0; m_hit = 0;
                if (promisc_en && dst_addr[0] == 1'b0) m_acc = 1;
                else if (mcast_en && dst_addr[0] == 1'b1) begin m_acc = 1; m_type = 'h100; end
                else if (bcast_en && dst_addr == 48'hFFFF_FFFF_FFFF) begin m_acc = 1; m_type = 'h80; end
                else begin
                    for (int i = 0; i < 16; i++)
                        if (!m_acc && m_mask[i] && m_ent[i] == dst_addr) begin
                            m_acc = 1; m_hit = i;
                        end
                end
            end
            m_done = 0;
            if (m_ph == -1) begin
                if (load_start) begin
                    m_cnt = load_count & 31; m_idx = 0;
                    m_ph = (m_cnt != 0) ? 0 : 3;
                end
            end else if (word_valid) begin
                if (m_ph == 3) begin
                    m_mask = word_data; m_ph = -1; m_done = 1;
                end else begin
                    m_ent[m_idx][16*m_ph +: 16] = word_data;
                    if (m_ph == 2) begin
                        m_idx = (m_idx + 1) % 16; m_cnt = m_cnt - 1;
                        m_ph = (m_cnt != 0) ? 0 : 3;
                    end else m_ph = m_ph + 1;
                end
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            int exp_rd;
            exp_rd = (in_reset && rd_sel < 3) ? int'(m_ent[rd_ptr][16*rd_sel +: 16]) : 0;
            chk("R9 accept", int'(accept), int'(m_acc));
            chk("R9 type", int'(rx_type), m_type);
            chk("R8 hit_entry", int'(hit_entry), m_hit);
            chk("R4 load_busy", int'(load_busy), int'(m_ph != -1));
            chk("R4 load_done", int'(load_done), int'(m_done));
            chk("R3 load_left", int'(load_left), m_cnt);
            chk("R10 rd_data", int'(rd_data), exp_rd);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !finished) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic push(input logic [15:0] w);
        word_valid = 1'b1; word_data = w;
        @(negedge clk);
        word_valid = 1'b0;
    endtask

    task automatic push_entry(input logic [47:0] a);
        push(a[15:0]); @(negedge clk);   // gap cycle: word_valid low is ignored
        push(a[31:16]); push(a[47:32]);
    endtask

    task automatic start(input logic [15:0] c);
        load_start = 1'b1; load_count = c;
        @(negedge clk);
        load_start = 1'b0;
    endtask

    task automatic classify(input logic [47:0] a);
        dst_valid = 1'b1; dst_addr = a;
        @(negedge clk);
        dst_valid = 1'b0; dst_addr = 48'h0123_4567_89AA;
        repeat (2) @(negedge clk);       // R9 hold window
    endtask

    localparam logic [47:0] A_UNI = 48'h5544_3322_1102;
    localparam logic [47:0] A_GRP = 48'h0000_00AB_CD01;
    localparam logic [47:0] A_BC  = 48'hFFFF_FFFF_FFFF;
    localparam logic [47:0] A_OTH = 48'h0A0B_0C0D_0E10;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state compared by the model
        chk("R1 accept", int'(accept), 0);
        chk("R1 load_left", int'(load_left), 0);
        in_reset = 1'b1;
        // R2: upper count bits ignored (0x0023 -> 3 entries)
        start(16'h0023);
        chk("R2 load_left", int'(load_left), 3);
        push_entry(A_UNI);
        chk("R3 left after entry0", int'(load_left), 2);
        push_entry(A_GRP);
        push_entry(A_UNI);
        push(16'h0006);                  // R4: entry 0 disabled
        chk("R4 idle after mask", int'(load_busy), 0);
        // R10: readback in reset mode
        for (int p = 0; p < 3; p++)
            for (int s = 0; s < 4; s++) begin
                rd_ptr = 4'(p); rd_sel = 2'(s); @(negedge clk);
            end
        rd_ptr = 4'd0; rd_sel = 2'd1; @(negedge clk);
        chk("R10 entry0 word1", int'(rd_data), 16'h3322);
        in_reset = 1'b0; @(negedge clk);
        chk("R10 gated", int'(rd_data), 0);
        // R8: disabled entry 0 skipped, duplicate at entry 2 hits
        classify(A_UNI);
        chk("R8 hit 2", int'(hit_entry), 2);
        classify(A_GRP);
        classify(A_OTH);
        chk("R8 reject", int'(accept), 0);
        classify(A_BC);
        // R5: promiscuous unicast
        promisc_en = 1'b1;
        classify(A_OTH);
        chk("R5 promisc", int'(accept), 1);
        classify(A_GRP);                 // group not covered by promisc, table hit
        // R6: all-multicast, also beats broadcast
        mcast_en = 1'b1; bcast_en = 1'b1;
        classify(A_GRP);
        chk("R6 mcast type", int'(rx_type), 16'h0100);
        classify(A_BC);
        chk("R6 bcast as mcast", int'(rx_type), 16'h0100);
        // R7: broadcast only
        promisc_en = 1'b0; mcast_en = 1'b0;
        classify(A_BC);
        chk("R7 bcast type", int'(rx_type), 16'h0080);
        classify(48'hFFFF_FFFF_FFFE);
        // R4: zero count loads mask only; R8 lowest index wins
        start(16'h0020);
        push(16'h0007);
        classify(A_UNI);
        chk("R8 first match", int'(hit_entry), 0);
        // R9: strobe during load sees the old table
        start(16'h0001);
        dst_valid = 1'b1; dst_addr = A_UNI; push(16'hBEEF);
        dst_valid = 1'b0;
        push(16'h0000); push(16'h0000); push(16'h0001);
        classify(A_UNI);
        repeat (3) @(negedge clk);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule